// File: doc/BRIEF.md
# Voltage-Identification Code Settle and Fault Blanking Controller

This block sits between the six raw voltage-identification inputs of a multiphase regulator and the logic that uses them. Because the six bits never switch at exactly the same instant, a raw sample taken during a transition can be a code that was never requested. The block only takes a new code once the inputs have stopped moving for a settle window of at least 400 ns. Any further edge restarts that window. It decodes the accepted code into a target voltage and raises a one-cycle pulse that tells the soft-start ramp to move toward the new target.

A change of output voltage carries the regulated output through ranges that the power-good and overvoltage comparators would flag. The block therefore opens a blanking window on the first input edge of a transition, and each later edge of the same transition restarts it. While a window is open, the power-good output keeps its last value and the crowbar output is held inactive. The crowbar window is at least 100 µs and the power-good window is 200 µs by default. Both lengths, and the settle time, are converted into clock-cycle counts from the clock frequency parameter. A low enable always forces power-good low.

Top module: `vid_settle_blank`

## Requirements
- R1: After reset the accepted code is 0, the target reads 3100, and `code_chg`, `pg_out` and `cb_out` are all low.
- R2: A code is accepted exactly ST_CYC rising edges after the edge that sampled the last input change (ST_CYC = ceil(SETTLE_NS·CLK_MHZ/1000), 40 by default). Until then `vid_code` keeps its previous value.
- R3: Any input change during a settle window restarts the full ST_CYC count.
- R4: For codes 0 to 31, `vtgt_hmv` equals 3100 − 50·code, in units of 0.5 mV (1.550 V down to 0.775 V).
- R5: For codes 32 to 63, `vtgt_hmv` equals 1525 − 25·(code − 32), in units of 0.5 mV (0.7625 V down to 0.375 V).
- R6: `code_chg` is high for exactly one cycle, together with the update of `vid_code`, and only when the accepted code differs from the previous one. An input that bounces back to the accepted code gives no pulse.
- R7: `cb_out` stays low on the edge that samples an input change and for the next CB_CYC edges (CB_BLANK_US·CLK_MHZ). Every further change restarts this count.
- R8: `pg_out` holds its value on the edge that samples an input change and for the next PG_CYC edges (PG_BLANK_US·CLK_MHZ). Every further change restarts this count.
- R9: When `en` is low, `pg_out` is low one edge later, even inside a blanking window.
- R10: Outside the blanking windows, `pg_out` follows `pg_raw & en` and `cb_out` follows `ov_raw`, each one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vid_raw | input | 6 | Raw voltage-identification code |
| en | input | 1 | Regulator enable |
| pg_raw | input | 1 | Raw power-good comparator flag |
| ov_raw | input | 1 | Raw overvoltage comparator flag |
| vid_code | output | 6 | Accepted code |
| vtgt_hmv | output | 12 | Target voltage of accepted code, 0.5 mV units |
| code_chg | output | 1 | One-cycle pulse on acceptance of a different code |
| pg_out | output | 1 | Blanked power-good |
| cb_out | output | 1 | Blanked crowbar request |

## Verification
The bench changes the inputs at a falling edge. Call the next rising edge E0, the edge that samples the change. The accepted code and the change pulse are due at edge E0+ST_CYC. The crowbar output is masked through E0+CB_CYC and can rise at E0+CB_CYC+1. Power-good is held through E0+PG_CYC and follows its comparator again from E0+PG_CYC+1. Each check samples at the falling edge after the edge where a result is due, and also one edge earlier, so a result that arrives a cycle early or a cycle late is caught. Enable and the unblanked comparator flags are checked one edge after they are driven.

// File: rtl/vid_settle_blank.sv
module vid_settle_blank #(
  parameter int unsigned CLK_MHZ     = 100,
  parameter int unsigned SETTLE_NS   = 400,
  parameter int unsigned PG_BLANK_US = 200,
  parameter int unsigned CB_BLANK_US = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] vid_raw,
  input  logic       en,
  input  logic       pg_raw,
  input  logic       ov_raw,
  output logic [5:0] vid_code,
  output logic [11:0] vtgt_hmv,
  output logic       code_chg,
  output logic       pg_out,
  output logic       cb_out
);

  localparam int unsigned ST_CYC = (SETTLE_NS * CLK_MHZ + 999) / 1000;
  localparam int unsigned PG_CYC = PG_BLANK_US * CLK_MHZ;
  localparam int unsigned CB_CYC = CB_BLANK_US * CLK_MHZ;
  localparam int STW = $clog2(ST_CYC + 1);
  localparam int PGW = $clog2(PG_CYC + 1);
  localparam int CBW = $clog2(CB_CYC + 1);
  localparam logic [STW-1:0] ST_LD = STW'(ST_CYC);
  localparam logic [PGW-1:0] PG_LD = PGW'(PG_CYC);
  localparam logic [CBW-1:0] CB_LD = CBW'(CB_CYC);

  logic [5:0]     vid_q;
  logic [STW-1:0] st_cnt;
  logic [PGW-1:0] pg_cnt;
  logic [CBW-1:0] cb_cnt;

  wire edge_seen = (vid_raw != vid_q);
  wire accept    = !edge_seen && (st_cnt == STW'(1));
  wire pg_mask   = edge_seen || (pg_cnt != '0);
  wire cb_mask   = edge_seen || (cb_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vid_q    <= '0;
      st_cnt   <= ST_LD;
      pg_cnt   <= '0;
      cb_cnt   <= '0;
      vid_code <= '0;
      code_chg <= 1'b0;
    end else begin
      vid_q    <= vid_raw;
      code_chg <= accept && (vid_q != vid_code);
      if (accept) vid_code <= vid_q;
      if (edge_seen) begin
        st_cnt <= ST_LD;
        pg_cnt <= PG_LD;
        cb_cnt <= CB_LD;
      end else begin
        if (st_cnt != '0) st_cnt <= st_cnt - 1'b1;
        if (pg_cnt != '0) pg_cnt <= pg_cnt - 1'b1;
        if (cb_cnt != '0) cb_cnt <= cb_cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_out <= 1'b0;
      cb_out <= 1'b0;
    end else begin
      cb_out <= ov_raw && !cb_mask;
      if (!en)          pg_out <= 1'b0;
      else if (!pg_mask) pg_out <= pg_raw;
    end
  end

  wire [11:0] step = 12'(vid_code[4:0]);
  assign vtgt_hmv = vid_code[5] ? (12'd1525 - step * 12'd25)
                                : (12'd3100 - step * 12'd50);

endmodule

// File: rtl/vid_settle_blank_chk.sv
module vid_settle_blank_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] vid_raw,
  input logic       en,
  input logic [5:0] vid_code,
  input logic       code_chg,
  input logic       pg_out,
  input logic       cb_out
);

  // R2
  accept_from_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_code != $past(vid_code)) |-> ($past(vid_raw) == vid_code));

  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_chg |=> !code_chg);

  // R6
  pulse_means_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_chg |-> (vid_code != $past(vid_code)));

  // R7
  cb_masked_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_raw != $past(vid_raw)) |=> !cb_out);

  // R8
  pg_held_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((vid_raw != $past(vid_raw)) && en) |=> (pg_out == $past(pg_out)));

  // R9
  pg_off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pg_out);

endmodule

bind vid_settle_blank vid_settle_blank_chk chk_i (
  .clk(clk), .rst_n(rst_n), .vid_raw(vid_raw), .en(en),
  .vid_code(vid_code), .code_chg(code_chg), .pg_out(pg_out), .cb_out(cb_out)
);

// File: tb/vid_settle_blank_test.sv
module vid_settle_blank_test;
  localparam int S  = 40;
  localparam int CB = 10000;
  localparam int PG = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] vid_raw = '0;
  logic en = 1'b0, pg_raw = 1'b0, ov_raw = 1'b0;
  logic [5:0] vid_code;
  logic [11:0] vtgt_hmv;
  logic code_chg, pg_out, cb_out;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  vid_settle_blank #(.CLK_MHZ(100), .SETTLE_NS(400), .PG_BLANK_US(200), .CB_BLANK_US(100)) uut (
    .clk(clk), .rst_n(rst_n), .vid_raw(vid_raw), .en(en), .pg_raw(pg_raw), .ov_raw(ov_raw),
    .vid_code(vid_code), .vtgt_hmv(vtgt_hmv), .code_chg(code_chg), .pg_out(pg_out), .cb_out(cb_out));

  // {code, expected target in 0.5 mV}
  localparam logic [17:0] VEC [8] = '{
    {6'd1,  12'd3050}, {6'd31, 12'd1550}, {6'd32, 12'd1525}, {6'd33, 12'd1500},
    {6'd63, 12'd750},  {6'd16, 12'd2300}, {6'd0,  12'd3100}, {6'd47, 12'd1150}};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [5:0] prev;
    repeat (3) @(negedge clk);
    eq("R1 code", int'(vid_code), 0);
    eq("R1 target", int'(vtgt_hmv), 3100);
    eq("R1 code_chg", int'(code_chg), 0);
    eq("R1 pg_out", int'(pg_out), 0);
    eq("R1 cb_out", int'(cb_out), 0);
    rst_n = 1'b1;
    repeat (S + 3) @(negedge clk);
    eq("R1 code after settle", int'(vid_code), 0);
    eq("R6 no pulse on same code", int'(code_chg), 0);

    // R10: no blanking active, flags pass with one edge latency
    en = 1'b1; pg_raw = 1'b1; ov_raw = 1'b1;
    @(posedge clk); @(negedge clk);
    eq("R10 pg follows", int'(pg_out), 1);
    eq("R10 cb follows", int'(cb_out), 1);
    ov_raw = 1'b0;
    @(posedge clk); @(negedge clk);
    eq("R10 cb drops", int'(cb_out), 0);

    // Decode and settle table
    prev = vid_code;
    for (int i = 0; i < 8; i++) begin
      logic [5:0] c;
      int t;
      c = VEC[i][17:12];
      t = int'(VEC[i][11:0]);
      vid_raw = c;
      @(posedge clk);
      repeat (S - 1) @(posedge clk);
      @(negedge clk);
      eq("R2 held before settle", int'(vid_code), int'(prev));
      @(posedge clk); @(negedge clk);
      eq("R2 accepted", int'(vid_code), int'(c));
      eq(c < 6'd32 ? "R4 target" : "R5 target", int'(vtgt_hmv), t);
      eq("R6 pulse high", int'(code_chg), 1);
      @(negedge clk);
      eq("R6 pulse one cycle", int'(code_chg), 0);
      prev = c;
    end

    // R3: restart of settle window
    vid_raw = 6'd10;
    repeat (S - 5) @(negedge clk);
    vid_raw = 6'd11;
    @(posedge clk);
    repeat (S - 1) @(posedge clk);
    @(negedge clk);
    eq("R3 restarted, still old", int'(vid_code), 47);
    @(posedge clk); @(negedge clk);
    eq("R3 accepted after restart", int'(vid_code), 11);

    // R6: bounce back to accepted code gives no pulse
    begin
      int pulses = 0;
      vid_raw = 6'd12;
      @(negedge clk);
      vid_raw = 6'd11;
      for (int k = 0; k < S + 4; k++) begin
        @(negedge clk);
        if (code_chg) pulses++;
      end
      eq("R6 bounce no pulse", pulses, 0);
      eq("R6 bounce code kept", int'(vid_code), 11);
    end

    // Let previous windows expire
    repeat (PG + 5) @(negedge clk);
    eq("R10 pg before blank test", int'(pg_out), 1);

    // R7 / R8: blanking with restart
    vid_raw = 6'd5; pg_raw = 1'b0; ov_raw = 1'b1;
    @(posedge clk);
    repeat (4999) @(posedge clk);
    @(negedge clk);
    eq("R7 cb masked in window", int'(cb_out), 0);
    eq("R8 pg held in window", int'(pg_out), 1);
    vid_raw = 6'd6;
    @(posedge clk);
    repeat (CB) @(posedge clk);
    @(negedge clk);
    eq("R7 cb masked after restart", int'(cb_out), 0);
    eq("R8 pg held after restart", int'(pg_out), 1);
    @(posedge clk); @(negedge clk);
    eq("R7 cb released", int'(cb_out), 1);
    repeat (PG - CB - 1) @(posedge clk);
    @(negedge clk);
    eq("R8 pg held to end", int'(pg_out), 1);
    @(posedge clk); @(negedge clk);
    eq("R8 pg released", int'(pg_out), 0);

    // R9: enable low overrides blanking
    ov_raw = 1'b0; pg_raw = 1'b1;
    @(posedge clk); @(negedge clk);
    eq("R10 pg follows again", int'(pg_out), 1);
    vid_raw = 6'd8;
    @(posedge clk); @(negedge clk);
    eq("R8 pg held on new change", int'(pg_out), 1);
    en = 1'b0;
    @(posedge clk); @(negedge clk);
    eq("R9 pg forced low", int'(pg_out), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule